// File: doc/BRIEF.md
# Three-Channel Quantum PWM Bank

This block produces three independent pulse-width-modulated outputs. Each output is programmed through a byte-wide register bus that has separate write and read strobes. Every channel has a 4-bit frequency selector F. It divides the system clock into time quanta of (32 − F) clock cycles each. A PWM period always spans 1024 quanta. With the nominal 9.6 MHz clock, this gives period rates from about 293 Hz (F = 0) to about 551 Hz (F = 15).

The high time of each channel is set in whole quanta, from 1 to 1024. It is stored as the high time minus one in a 10-bit field. The low 8 bits of that field have their own byte. The top 2 bits share a second byte with the frequency selector. A single shared byte holds one run bit per channel.

A stopped channel drives low, and its counters are held at zero. When a channel is started, it begins a fresh period at once. While a channel runs, new duty and frequency values wait in the registers. They are copied into the running channel only at the end of a period, so no period is ever cut short or stretched.

Top module: `qpwm_bank`

## Requirements
- R1: After reset, every register reads zero and all three outputs are low.
- R2: Channel n (n = 0..2) has its duty field bits [7:0] at address 0x60+2n. The byte at 0x61+2n holds duty field bits [9:8] in bits [1:0] and F in bits [7:4]. The byte at 0x66 holds the run bits, with bit n starting channel n.
- R3: A read strobe loads `bus_rdata` at that clock edge, so the data is valid in the following cycle. It returns the stored contents, and bits [3:2] of each 0x61+2n byte read as zero whatever was written to them.
- R4: A read of any address other than the seven mapped bytes returns zero.
- R5: One quantum lasts (32 − F) clock cycles, and one PWM period lasts exactly 1024 quanta.
- R6: Within a period, the output is high for (field + 1) quanta, starting at the period start. A field of 0 gives a one-quantum pulse. A field of 1023 keeps the output high with no low cycle at all.
- R7: In the cycle after a write sets a run bit, that channel's output is high and a fresh period begins.
- R8: In the cycle after a write clears a run bit, that channel's output is low.
- R9: A duty or frequency write to a running channel leaves the current period unchanged and takes effect from the next period.
- R10: The channels run independently, each with its own F and duty, and stopping one channel does not disturb the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, registered on the read strobe |
| pwm_out | output | 3 | PWM outputs, bit n belongs to channel n |

## Verification
The in-RTL properties assume three things about the inputs: each bus strobe lasts one cycle, the address is steady while a strobe is high, and reset is held across at least one clock edge. The prescaler range check also assumes that a channel only ever runs on the F value latched at a period boundary, which holds because stopped channels reload their working copies every cycle. The bench drives every strobe from the falling edge for exactly one cycle. It changes the run byte only when it is not also writing that channel's duty or frequency bytes, and it releases reset on a falling edge after several held cycles.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

   // Clock cycles per quantum are QPWM_DIV_BASE minus the frequency selector
   localparam int unsigned QPWM_DIV_BASE = 32;

   function automatic int unsigned qpwm_quantum(input int unsigned sel);
      return QPWM_DIV_BASE - sel;
   endfunction

endpackage

// File: rtl/qpwm_regs.sv
module qpwm_regs #(
   parameter int unsigned NUM_CH    = 3,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CNT_W     = 10,
   parameter int unsigned FREQ_W    = 4,
   parameter logic [7:0]  BASE_ADDR = 8'h60,
   parameter logic [7:0]  RUN_ADDR  = 8'h66
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [DATA_W-1:0]                 wdata,
   input  logic                              we,
   input  logic                              re,
   output logic [DATA_W-1:0]                 rdata,
   output logic [NUM_CH-1:0][CNT_W-1:0]      duty_o,
   output logic [NUM_CH-1:0][FREQ_W-1:0]     freq_o,
   output logic [NUM_CH-1:0]                 run_o
);

   localparam int unsigned HI_W  = CNT_W - DATA_W;
   localparam int unsigned F_LSB = DATA_W - FREQ_W;
   localparam int unsigned SPAN  = 2 * NUM_CH;

   if (HI_W < 1 || HI_W > F_LSB) begin : g_bad_split
      $error("duty high bits must fit below the frequency field");
   end
   if (NUM_CH > DATA_W) begin : g_bad_run
      $error("run byte cannot hold one bit per channel");
   end
   if (int'(RUN_ADDR) >= int'(BASE_ADDR) && int'(RUN_ADDR) < int'(BASE_ADDR) + int'(SPAN)) begin : g_bad_map
      $error("run byte overlaps channel bytes");
   end

   logic [NUM_CH-1:0][DATA_W-1:0] lo_q;
   logic [NUM_CH-1:0][HI_W-1:0]   hi_q;
   logic [NUM_CH-1:0][FREQ_W-1:0] f_q;
   logic [NUM_CH-1:0]             run_q;
   logic [NUM_CH-1:0]             lo_hit, hi_hit;
   logic                          run_hit, mapped;
   logic [DATA_W-1:0]             rd_next;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
      localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(int'(BASE_ADDR) + 2 * g);
      localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(int'(BASE_ADDR) + 2 * g + 1);
      assign lo_hit[g] = (addr == LO_A);
      assign hi_hit[g] = (addr == HI_A);
      assign duty_o[g] = {hi_q[g], lo_q[g]};
      assign freq_o[g] = f_q[g];
   end

   assign run_hit = (addr == ADDR_W'(RUN_ADDR));
   assign mapped  = (|lo_hit) | (|hi_hit) | run_hit;
   assign run_o   = run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         f_q   <= '0;
         run_q <= '0;
      end else if (we) begin
         for (int c = 0; c < int'(NUM_CH); c++) begin
            if (lo_hit[c]) lo_q[c] <= wdata;
            if (hi_hit[c]) begin
               hi_q[c] <= wdata[HI_W-1:0];
               f_q[c]  <= wdata[DATA_W-1 -: FREQ_W];
            end
         end
         if (run_hit) run_q <= wdata[NUM_CH-1:0];
      end
   end

   always_comb begin
      rd_next = '0;
      for (int c = 0; c < int'(NUM_CH); c++) begin
         if (lo_hit[c]) rd_next = lo_q[c];
         if (hi_hit[c]) begin
            rd_next[DATA_W-1 -: FREQ_W] = f_q[c];
            rd_next[HI_W-1:0]           = hi_q[c];
         end
      end
      if (run_hit) rd_next[NUM_CH-1:0] = run_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= rd_next;
   end

   // R4
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (re && !mapped) |=> (rdata == '0));

   // R3
   rsvd_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (re && (|hi_hit)) |=> (rdata[F_LSB-1:HI_W] == '0));

endmodule

// File: rtl/qpwm_chan.sv
module qpwm_chan
   import qpwm_pkg::*;
#(
   parameter int unsigned CNT_W     = 10,
   parameter int unsigned FREQ_W    = 4,
   parameter bit          SHADOW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [CNT_W-1:0]  duty_i,
   input  logic [FREQ_W-1:0] freq_i,
   output logic              pwm_o
);

   localparam int unsigned DIV_W = $clog2(QPWM_DIV_BASE + 1);

   if ((1 << FREQ_W) > QPWM_DIV_BASE) begin : g_bad_freq
      $error("frequency field can select a zero-length quantum");
   end

   logic [DIV_W-1:0]  presc;
   logic [DIV_W-1:0]  div;
   logic [CNT_W-1:0]  qcnt;
   logic [CNT_W-1:0]  duty_sh;
   logic [FREQ_W-1:0] f_sh;
   logic              q_tick, boundary;

   assign div      = DIV_W'(qpwm_quantum(int'(f_sh)));
   assign q_tick   = (presc >= div - DIV_W'(1));
   assign boundary = q_tick && (qcnt == '1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         presc <= '0;
         qcnt  <= '0;
      end else if (q_tick) begin
         presc <= '0;
         qcnt  <= qcnt + CNT_W'(1);
      end else begin
         presc <= presc + DIV_W'(1);
      end
   end

   if (SHADOW_EN) begin : g_shadow
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            duty_sh <= '0;
            f_sh    <= '0;
         end else if (!run_i || boundary) begin
            duty_sh <= duty_i;
            f_sh    <= freq_i;
         end
      end

      // R9
      shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run_i && !boundary) |=> (!run_i || ($stable(duty_sh) && $stable(f_sh))));

      // R5
      presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         run_i |-> (presc < div));
   end else begin : g_direct
      assign duty_sh = duty_i;
      assign f_sh    = freq_i;
   end

   assign pwm_o = run_i && (qcnt <= duty_sh);

   // R5
   quantum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !q_tick) |=> (!run_i || $stable(qcnt)));

   // R7
   restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_i) |-> (pwm_o && qcnt == '0 && presc == '0));

endmodule

// File: rtl/qpwm_bank.sv
module qpwm_bank #(
   parameter int unsigned NUM_CH    = 3,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PERIOD_Q  = 1024,
   parameter int unsigned FREQ_W    = 4,
   parameter logic [7:0]  BASE_ADDR = 8'h60,
   parameter logic [7:0]  RUN_ADDR  = 8'h66,
   parameter bit          SHADOW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int unsigned CNT_W = $clog2(PERIOD_Q);

   if ((1 << CNT_W) != PERIOD_Q) begin : g_bad_period
      $error("period length must be a power of two");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("address bus too narrow for the register map");
   end

   logic [NUM_CH-1:0][CNT_W-1:0]  duty_w;
   logic [NUM_CH-1:0][FREQ_W-1:0] freq_w;
   logic [NUM_CH-1:0]             run_w;

   qpwm_regs #(
      .NUM_CH   (NUM_CH),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .FREQ_W   (FREQ_W),
      .BASE_ADDR(BASE_ADDR),
      .RUN_ADDR (RUN_ADDR)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .we     (bus_we),
      .re     (bus_re),
      .rdata  (bus_rdata),
      .duty_o (duty_w),
      .freq_o (freq_w),
      .run_o  (run_w)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      qpwm_chan #(
         .CNT_W    (CNT_W),
         .FREQ_W   (FREQ_W),
         .SHADOW_EN(SHADOW_EN)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .run_i  (run_w[g]),
         .duty_i (duty_w[g]),
         .freq_i (freq_w[g]),
         .pwm_o  (pwm_out[g])
      );
   end

   // R8
   stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(RUN_ADDR)) |=> ((pwm_out & ~bus_wdata[NUM_CH-1:0]) == '0));

endmodule

// File: tb/test_qpwm_bank.sv
`timescale 1ns/1ps
module test_qpwm_bank;

   localparam int NCH = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic       we = 1'b0, re = 1'b0;
   logic [7:0] rdata;
   logic [2:0] pwm_out;
   logic [2:0] tb_run = '0;

   int total = 0, bad = 0;
   bit finished = 0;

   int exp_hi[NCH][$];
   int exp_per[NCH][$];

   always #2 clk = ~clk;

   qpwm_bank i_qpwm_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
      .bus_we(we), .bus_re(re), .bus_rdata(rdata), .pwm_out(pwm_out)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      if (a == 8'h66) tb_run = d[2:0];
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; re = 1'b1;
      @(negedge clk);
      re = 1'b0;
      d = rdata;
   endtask

   task automatic push_exp(input int ch, input int hi, input int per);
      exp_hi[ch].push_back(hi);
      exp_per[ch].push_back(per);
   endtask

   // Monitor: measures each complete period from rising edge to rising edge
   int  hc[NCH], pc[NCH];
   bit  seen[NCH], prev[NCH];
   initial for (int c = 0; c < NCH; c++) begin hc[c] = 0; pc[c] = 0; seen[c] = 0; prev[c] = 0; end

   always @(negedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         bit cur;
         cur = pwm_out[c];
         if (!rst_n || !tb_run[c]) begin
            seen[c] = 0;
         end else begin
            if (cur && !prev[c]) begin
               if (seen[c] && exp_hi[c].size() > 0) begin
                  int eh, ep;
                  eh = exp_hi[c].pop_front();
                  ep = exp_per[c].pop_front();
                  check($sformatf("R6 high time ch%0d", c), hc[c], eh);
                  check($sformatf("R5 period ch%0d", c), pc[c], ep);
               end
               seen[c] = 1; hc[c] = 0; pc[c] = 0;
            end
            if (seen[c]) begin
               pc[c]++;
               if (cur) hc[c]++;
            end
         end
         prev[c] = cur;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int lows;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 outputs low", int'(pwm_out), 0);
      rd(8'h60, d); check("R1 duty low reg", d, 0);
      rd(8'h61, d); check("R1 duty/freq reg", d, 0);
      rd(8'h66, d); check("R1 run reg", d, 0);

      // Program: ch0 F=15 field 0, ch1 F=14 field 1023, ch2 F=15 field 511
      wr(8'h60, 8'h00); wr(8'h61, 8'hF0);
      wr(8'h62, 8'hFF); wr(8'h63, 8'hE3);
      wr(8'h64, 8'hFF); wr(8'h65, 8'hFD);

      // R2 / R3 readback, reserved bits [3:2] read zero
      rd(8'h61, d); check("R2 ch0 freq byte", d, 8'hF0);
      rd(8'h63, d); check("R2 ch1 freq byte", d, 8'hE3);
      rd(8'h62, d); check("R2 ch1 duty low", d, 8'hFF);
      rd(8'h65, d); check("R3 ch2 reserved bits cleared", d, 8'hF1);

      // R4 unmapped reads
      rd(8'h67, d); check("R4 addr 0x67", d, 0);
      rd(8'h5F, d); check("R4 addr 0x5F", d, 0);
      rd(8'hE0, d); check("R4 addr 0xE0", d, 0);

      // Expected periods: ch0 17/17408 then shadowed field 99 -> 1700
      push_exp(0, 17, 17408);
      push_exp(0, 1700, 17408);
      // ch2 512*17 then F=12 -> 512*20 over 1024*20
      push_exp(2, 8704, 17408);
      push_exp(2, 10240, 20480);

      wr(8'h66, 8'h07);
      check("R7 all start high", int'(pwm_out), 7);
      rd(8'h66, d); check("R2 run byte", d, 7);

      // R9 writes during the first period (ch0 still inside its 17-cycle pulse)
      wr(8'h60, 8'd99);
      wr(8'h65, 8'hC1);

      // R6 ch1 field 1023: never low over two periods
      lows = 0;
      for (int i = 0; i < 2 * 18432; i++) begin
         @(negedge clk);
         if (!pwm_out[1]) lows++;
      end
      check("R6 ch1 full duty low cycles", lows, 0);
      repeat (2000) @(negedge clk);
      check("R9 ch0 expected periods seen", exp_hi[0].size(), 0);
      check("R10 ch2 expected periods seen", exp_hi[2].size(), 0);

      // R8 stop ch1 only
      wr(8'h66, 8'h05);
      check("R8 ch1 low after stop", int'(pwm_out[1]), 0);
      wr(8'h66, 8'h00);
      check("R8 all low after stop", int'(pwm_out), 0);

      // Restart ch1 with F=0 field 2: 3*32 high over 1024*32
      wr(8'h62, 8'h02); wr(8'h63, 8'h00);
      push_exp(1, 96, 32768);
      wr(8'h66, 8'h02);
      check("R7 ch1 restart high", int'(pwm_out), 2);
      repeat (2 * 32768 + 100) @(negedge clk);
      check("R5 ch1 F=0 period seen", exp_hi[1].size(), 0);
      check("R10 ch0 idle while stopped", int'(pwm_out[0]), 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule